// File: doc/BRIEF.md
# Mirrored Low-Resolution Background Serializer

This block turns a 20-bit background pattern into one pixel bit per pixel clock across a 160-pixel visible scanline. Three byte-write ports load the pattern in slices. One control write sets the mode bit. In repeat mode the right half of the line carries the same bit sequence as the left half. In mirror mode the right half carries that sequence in reverse.

The line timing comes from outside the block. A pixel-clock enable advances the scan. A horizontal-blank marker clears the output and rewinds the scan, so every line starts at the left edge of the visible area. A half-line marker tells the block when the right half begins. The block has no horizontal position of its own. Colour and collision logic downstream take the registered pixel bit.

Top module: `bgser_top`

## Requirements
- R1: After a synchronous reset the pixel output is 0, the pattern is all zeros and repeat mode is selected.
- R2: On an enabled clock with horizontal blank high, the output becomes 0 and the scan rewinds to pattern bit 0.
- R3: For visible pixel n, with n from 0 to 79 counted in enabled clocks after blank ends, the output is pattern bit n/4 (integer division). Bit 0 comes first and each bit lasts 4 enabled clocks.
- R4: With the mode bit at 0, visible pixel 80+k (k from 0 to 79) shows pattern bit k/4, repeating the left-half order.
- R5: With the mode bit at 1, visible pixel 80+k shows pattern bit 19-k/4, reversing the left-half order.
- R6: Port 0 writes data bits [7:4] into pattern bits [3:0] and ignores data bits [3:0]. Port 1 writes data [7:0] into bits [11:4]. Port 2 writes data [7:0] into bits [19:12]. The control write copies data bit 0 into the mode bit.
- R7: A clock with the pixel enable low changes neither the output nor the scan position.
- R8: Writes are accepted at any time. A pattern or mode write that lands on a clock edge takes effect from the next enabled pixel, so a write made mid-line shows up in the bits output later on that line.
- R9: A write changes only its own slice of the pattern. Writing zero to one port leaves the bits of the other ports in place.
- R10: The output is registered. It shows the pixel selected at a clock edge from just after that edge until the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel per enabled edge |
| hblank | input | 1 | Horizontal blank marker from the line timing |
| half_mark | input | 1 | High during the right half of the visible line |
| wr_en | input | 3 | Per-port pattern write strobes (bit p selects port p) |
| ctl_wr | input | 1 | Control write strobe; loads the mode bit from wr_data[0] |
| wr_data | input | 8 | Shared write data byte |
| pix_out | output | 1 | Registered background pixel bit |

## Verification
The checker tests on every cycle that an enabled blank clock drives the output to 0 and that a disabled clock holds it. It also tests that the scan index never leaves the 20-bit range and that an all-zero pattern never produces a lit pixel. Only the bench's scenarios can show the bit ordering: repeat order against reversed order on the right half, the 4-clock bit width under a gated pixel enable, the slice mapping of the three ports, and mid-line writes. The bench shows these by comparing every cycle with a model that works from the pixel number alone.

// File: rtl/bgser_pkg.sv
package bgser_pkg;
  localparam int PAT_W   = 20;
  localparam int DATA_W  = 8;
  localparam int N_PORTS = 3;
  localparam int REP     = 4;

  function automatic int port_lo(input int p);
    case (p)
      0: return 0;
      1: return 4;
      default: return 12;
    endcase
  endfunction

  function automatic int port_w(input int p);
    case (p)
      0: return 4;
      1: return 8;
      default: return PAT_W - 12;
    endcase
  endfunction
endpackage

// File: rtl/bgser_patreg.sv
module bgser_patreg
  import bgser_pkg::*;
#(
  parameter int PW = PAT_W,
  parameter int DW = DATA_W,
  parameter int NP = N_PORTS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] wr_en,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wr_data,
  output logic [PW-1:0] pat,
  output logic          mirror
);
  logic [PW-1:0] pat_d;
  logic [PW-1:0] field_val [NP];
  logic [PW-1:0] field_msk [NP];

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int LO = port_lo(p);
    localparam int W  = port_w(p);
    assign field_msk[p] = {{(PW-W){1'b0}}, {W{1'b1}}} << LO;
    assign field_val[p] = {{(PW-W){1'b0}}, wr_data[DW-1 -: W]} << LO;
  end

  always_comb begin
    pat_d = pat;
    for (int p = 0; p < NP; p++) begin
      if (wr_en[p]) pat_d = (pat_d & ~field_msk[p]) | field_val[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat    <= '0;
      mirror <= 1'b0;
    end else begin
      pat <= pat_d;
      if (ctl_wr) mirror <= wr_data[0];
    end
  end
endmodule

// File: rtl/bgser_scan.sv
module bgser_scan
  import bgser_pkg::*;
#(
  parameter int PW = PAT_W,
  parameter int RP = REP
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pix_en,
  input  logic                  hblank,
  input  logic                  half_mark,
  input  logic                  mirror,
  output logic [$clog2(PW)-1:0] sel
);
  localparam int IW = $clog2(PW);
  localparam int SW = (RP > 1) ? $clog2(RP) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(PW - 1);
  localparam logic [SW-1:0] LAST_SUB = SW'(RP - 1);

  logic [IW-1:0] idx_q, cur_idx;
  logic [SW-1:0] sub_q, cur_sub;
  logic          right_q, restart;

  always_comb begin
    restart = half_mark && !right_q;
    cur_idx = restart ? '0 : idx_q;
    cur_sub = restart ? '0 : sub_q;
    sel     = (half_mark && mirror) ? (LAST_IDX - cur_idx) : cur_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      sub_q   <= '0;
      right_q <= 1'b0;
    end else if (pix_en) begin
      if (hblank) begin
        idx_q   <= '0;
        sub_q   <= '0;
        right_q <= 1'b0;
      end else begin
        right_q <= half_mark;
        if (cur_sub == LAST_SUB) begin
          sub_q <= '0;
          idx_q <= (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
        end else begin
          sub_q <= cur_sub + 1'b1;
          idx_q <= cur_idx;
        end
      end
    end
  end
endmodule

// File: rtl/bgser_outreg.sv
module bgser_outreg
  import bgser_pkg::*;
#(
  parameter int PW = PAT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pix_en,
  input  logic                  hblank,
  input  logic [PW-1:0]         pat,
  input  logic [$clog2(PW)-1:0] sel,
  output logic                  pix_out
);
  always_ff @(posedge clk) begin
    if (rst)         pix_out <= 1'b0;
    else if (pix_en) pix_out <= hblank ? 1'b0 : pat[sel];
  end
endmodule

// File: rtl/bgser_top.sv
module bgser_top
  import bgser_pkg::*;
#(
  parameter int PW = PAT_W,
  parameter int DW = DATA_W,
  parameter int NP = N_PORTS,
  parameter int RP = REP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          hblank,
  input  logic          half_mark,
  input  logic [NP-1:0] wr_en,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wr_data,
  output logic          pix_out
);
  localparam int IW = $clog2(PW);

  logic [PW-1:0] pat;
  logic          mirror;
  logic [IW-1:0] sel;

  bgser_patreg #(.PW(PW), .DW(DW), .NP(NP)) u_patreg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ctl_wr(ctl_wr),
    .wr_data(wr_data), .pat(pat), .mirror(mirror)
  );

  bgser_scan #(.PW(PW), .RP(RP)) u_scan (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hblank(hblank),
    .half_mark(half_mark), .mirror(mirror), .sel(sel)
  );

  bgser_outreg #(.PW(PW)) u_outreg (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hblank(hblank),
    .pat(pat), .sel(sel), .pix_out(pix_out)
  );
endmodule

// File: rtl/bgser_chk.sv
module bgser_chk #(
  parameter int PW = 20,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic          hblank,
  input logic          pix_out,
  input logic [PW-1:0] pat,
  input logic [IW-1:0] sel
);
  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  p_reset_dark_r1: assert property (@(posedge clk) rst |=> !pix_out);

  p_blank_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hblank) |=> !pix_out);

  p_hold_disabled_r7: assert property (@(posedge clk) disable iff (rst || !started)
    !pix_en |=> $stable(pix_out));

  p_empty_dark_r9: assert property (@(posedge clk) disable iff (rst)
    (pix_en && pat == '0) |=> !pix_out);

  p_index_range_r3: assert property (@(posedge clk) disable iff (rst)
    32'(sel) < PW);
endmodule

bind bgser_top bgser_chk #(.PW(PW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .hblank(hblank),
  .pix_out(pix_out), .pat(pat), .sel(sel)
);

// File: tb/bgser_top_bench.sv
`timescale 1ns/1ps
module bgser_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_en = 1'b0;
  logic       hblank = 1'b1;
  logic       half_mark = 1'b0;
  logic [2:0] wr_en = 3'b000;
  logic       ctl_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pix_out;

  always #2.5 clk = ~clk;

  bgser_top u_bgser_top (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hblank(hblank),
    .half_mark(half_mark), .wr_en(wr_en), .ctl_wr(ctl_wr),
    .wr_data(wr_data), .pix_out(pix_out)
  );

  int          vectors = 0;
  int          errors  = 0;
  bit          finished = 0;
  bit          have_exp = 0;
  logic        exp_out = 1'b0;
  string       exp_tag = "R1";
  logic [19:0] m_pat = '0;
  logic        m_mir = 1'b0;
  int          m_x = 0;

  // One clock: check the result of the previous edge (R10), drive, predict.
  task automatic step(input logic r, input logic en, input logic hb,
                      input logic hm, input logic [2:0] we, input logic cw,
                      input logic [7:0] d);
    int k;
    int b;
    @(negedge clk);
    if (have_exp) begin
      vectors++;
      if (pix_out !== exp_out) begin
        errors++;
        $display("FAIL %s x=%0d actual=%b expected=%b", exp_tag, m_x, pix_out, exp_out);
      end
    end
    rst = r; pix_en = en; hblank = hb; half_mark = hm;
    wr_en = we; ctl_wr = cw; wr_data = d;
    have_exp = 1;
    if (r) begin
      exp_out = 1'b0; exp_tag = "R1"; m_pat = '0; m_mir = 1'b0; m_x = 0;
    end else begin
      if (!en) begin
        exp_tag = "R7";
      end else if (hb) begin
        exp_out = 1'b0; exp_tag = "R2"; m_x = 0;
      end else begin
        if (m_x < 80) begin
          b = m_x / 4; exp_tag = "R3";
        end else begin
          k = m_x - 80;
          if (m_mir) begin b = 19 - k / 4; exp_tag = "R5"; end
          else       begin b = k / 4;      exp_tag = "R4"; end
        end
        exp_out = m_pat[b];
        m_x++;
      end
      // R6 slice mapping, applied after this edge's pixel (R8)
      if (we[0]) m_pat[3:0]   = d[7:4];
      if (we[1]) m_pat[11:4]  = d;
      if (we[2]) m_pat[19:12] = d;
      if (cw) m_mir = d[0];
    end
  endtask

  task automatic wr(input logic [2:0] we, input logic cw, input logic [7:0] d);
    step(1'b0, 1'b1, 1'b1, 1'b0, we, cw, d);
  endtask

  // Full line: 20 blank pixels then 160 visible; gap = disabled clocks per pixel.
  task automatic run_line(input int gap, input int wr_at,
                          input logic [2:0] we_mid, input logic [7:0] d_mid);
    for (int i = 0; i < 20; i++) begin
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00);
      step(1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00);
    end
    for (int x = 0; x < 160; x++) begin
      logic hm;
      hm = (x >= 80);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, hm, 3'b000, 1'b0, 8'h00);
      if (x == wr_at) step(1'b0, 1'b1, 1'b0, hm, we_mid, 1'b0, d_mid);
      else            step(1'b0, 1'b1, 1'b0, hm, 3'b000, 1'b0, 8'h00);
    end
    step(1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then a line from the cleared pattern
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00);
    run_line(0, -1, 3'b000, 8'h00);
    // R6: port 0 low nibble ignored; distinct slices; R4 repeat mode
    wr(3'b001, 1'b0, 8'hAF);
    wr(3'b010, 1'b0, 8'h3C);
    wr(3'b100, 1'b0, 8'hC5);
    run_line(0, -1, 3'b000, 8'h00);
    // R5: mirror mode via control bit 0
    wr(3'b000, 1'b1, 8'h01);
    run_line(0, -1, 3'b000, 8'h00);
    // R7: gated pixel enable, bits stretch over disabled clocks
    run_line(2, -1, 3'b000, 8'h00);
    // R8: mid-line write to port 2 while the left half is scanning
    run_line(0, 30, 3'b100, 8'h5A);
    // R8: mid-line write to port 0 during the right half in mirror mode
    run_line(0, 100, 3'b001, 8'h90);
    // R9: zero to port 1 only, other slices stay
    wr(3'b010, 1'b0, 8'h00);
    wr(3'b000, 1'b1, 8'h00);
    run_line(1, -1, 3'b000, 8'h00);
    // R9: clear all three slices, then mirror line must be dark
    wr(3'b111, 1'b1, 8'h01);
    wr(3'b111, 1'b0, 8'h00);
    run_line(0, -1, 3'b000, 8'h00);
    // all-ones pattern, simultaneous writes, mirror
    wr(3'b111, 1'b1, 8'hFF);
    run_line(0, -1, 3'b000, 8'h00);
    // R1: reset mid-use clears pattern and mode
    step(1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00);
    run_line(0, -1, 3'b000, 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 8'h00);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule